// File: doc/BRIEF.md
# Partitioned Scan Width Decompressor

The block lets a tester drive many internal scan chains from only a few external scan pins. Every internal chain takes its shift bit from the external bus, either as one external bit unchanged, as one external bit inverted, or as the XOR or XNOR of two external bits. Chains that can share data in a given part of the test set are therefore fed from one external bit. Only that shared data has to be stored on the tester.

The test set is split into partitions. Each partition has its own chain-to-input table, fixed at elaboration through one parameter. A partition number is loaded into a small register while scan shifting is off. During the shift that follows, one multiplexer per chain picks that chain's source for the active partition. The path from the external pins to the chains is purely combinational, so the shift adds no clock of latency. The default build has 16 external inputs and 64 internal chains, which is a ratio of 1:4 (75 % less external data), and 3 partitions.

Top module: `scan_width_decomp`

## Requirements
- R1: Each bit `c` of `scan_int_o` equals the function that the mapping entry of (active partition, chain `c`) selects, applied to the external bits that the entry names.
- R2: A mapping entry is 14 bits: {mode[13:12], src_b[11:6], src_a[5:0]}. The entry for partition `p` and chain `c` sits at bit offset (p*N_INT + c)*14 of `MAP`. The mode codes are 0 = ext[src_a], 1 = NOT ext[src_a], 2 = ext[src_a] XOR ext[src_b] and 3 = NOT (ext[src_a] XOR ext[src_b]).
- R3: The default table uses src_a = (c*(2p+1) + p) mod N_EXT, src_b = (src_a + p + 1) mod N_EXT and mode = (floor(c / N_EXT) + p) mod 4.
- R4: When `scan_en_i` is low at a rising clock edge and `part_sel_i` < N_PART, that partition becomes active from that edge on.
- R5: While `scan_en_i` is high at a clock edge, the active partition does not change, whatever `part_sel_i` carries.
- R6: A `part_sel_i` value of N_PART or more is ignored, and the previous partition stays active.
- R7: After reset, partition 0 is active. Reset is asynchronous and active low, and its release is synchronized through two flops.
- R8: `scan_int_o` follows a change on `scan_ext_i` within the same clock cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Scan shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | High while a vector is being shifted; low allows a partition load |
| part_sel_i | input | PSEL_W | Requested partition number |
| scan_ext_i | input | N_EXT | External scan-in bits |
| scan_int_o | output | N_INT | Scan-in bits to the internal chains |

## Verification
The assertions check on every clock edge that:
- the partition register holds while shifting is on;
- a legal request taken with shifting off is loaded;
- a request out of range leaves the register unchanged;
- the register never holds a number of N_PART or more;
- with shifting held on and stable external bits, the chain outputs do not move, so the output path carries no hidden state.

Only the bench scenarios show that the value on every chain matches the mapping table for each partition and mode. They also show that partition 0 is active after reset and that the outputs respond to a new external value inside the cycle.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

  localparam int SRC_W           = 6;
  localparam int ENTRY_W         = 2 + 2 * SRC_W;
  localparam int MAP_MAX_ENTRIES = 256;
  localparam int MAP_MAX_W       = MAP_MAX_ENTRIES * ENTRY_W;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_INV  = 2'd1,
    MODE_XOR  = 2'd2,
    MODE_XNOR = 2'd3
  } src_mode_e;

  typedef struct packed {
    src_mode_e        mode;
    logic [SRC_W-1:0] src_b;
    logic [SRC_W-1:0] src_a;
  } map_entry_t;

  // Default table: spreads sources and modes over every partition
  function automatic logic [MAP_MAX_W-1:0] default_map(int n_ext, int n_int, int n_part);
    logic [MAP_MAX_W-1:0] m;
    map_entry_t           e;
    int                   a;
    int                   b;
    int                   md;
    int                   idx;
    m = '0;
    for (int p = 0; p < n_part; p++) begin
      for (int c = 0; c < n_int; c++) begin
        idx = p * n_int + c;
        a   = (c * (2 * p + 1) + p) % n_ext;
        b   = (a + p + 1) % n_ext;
        md  = ((c / n_ext) + p) % 4;
        e.mode  = src_mode_e'(md[1:0]);
        e.src_a = a[SRC_W-1:0];
        e.src_b = b[SRC_W-1:0];
        if (idx < MAP_MAX_ENTRIES) begin
          m[idx*ENTRY_W +: ENTRY_W] = e;
        end
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/pswd_rst_sync.sv
module pswd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/pswd_part_reg.sv
module pswd_part_reg #(
  parameter int N_PART = 3,
  parameter int PSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_en_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic [PSEL_W-1:0] part_o
);

  localparam logic [PSEL_W:0] PART_LIM = N_PART[PSEL_W:0];

  logic [PSEL_W-1:0] part_q;
  logic [PSEL_W-1:0] part_d;
  logic              sel_legal;
  logic              load_en;

  always_comb begin
    sel_legal = ({1'b0, sel_i} < PART_LIM);
    load_en   = !scan_en_i && sel_legal;
    part_d    = sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q <= '0;
    end else if (load_en) begin
      part_q <= part_d;
    end
  end

  assign part_o = part_q;

  a_r5_hold_in_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |=> $stable(part_q));

  a_r4_load_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_i && ({1'b0, sel_i} < PART_LIM)) |=> (part_q == $past(sel_i)));

  a_r6_ignore_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_i && ({1'b0, sel_i} >= PART_LIM)) |=> $stable(part_q));

  a_r6_part_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, part_q} < PART_LIM));

endmodule

// File: rtl/pswd_chain_mux.sv
module pswd_chain_mux #(
  parameter int N_EXT  = 16,
  parameter int N_INT  = 64,
  parameter int N_PART = 3,
  parameter int PSEL_W = 2,
  parameter int CHAIN  = 0,
  parameter logic [pswd_pkg::MAP_MAX_W-1:0] MAP = '0
) (
  input  logic [N_EXT-1:0]  ext_i,
  input  logic [PSEL_W-1:0] part_i,
  output logic              chain_o
);

  logic [N_PART-1:0] cand;

  for (genvar p = 0; p < N_PART; p++) begin : g_part
    localparam pswd_pkg::map_entry_t ENT =
      pswd_pkg::map_entry_t'(MAP[(p*N_INT+CHAIN)*pswd_pkg::ENTRY_W +: pswd_pkg::ENTRY_W]);
    localparam int IA = int'(ENT.src_a) % N_EXT;
    localparam int IB = int'(ENT.src_b) % N_EXT;

    always_comb begin
      case (ENT.mode)
        pswd_pkg::MODE_PASS: cand[p] = ext_i[IA];
        pswd_pkg::MODE_INV:  cand[p] = ~ext_i[IA];
        pswd_pkg::MODE_XOR:  cand[p] = ext_i[IA] ^ ext_i[IB];
        default:             cand[p] = ~(ext_i[IA] ^ ext_i[IB]);
      endcase
    end
  end

  assign chain_o = cand[part_i];

endmodule

// File: rtl/scan_width_decomp.sv
module scan_width_decomp #(
  parameter int N_EXT  = 16,
  parameter int N_INT  = 64,
  parameter int N_PART = 3,
  parameter logic [pswd_pkg::MAP_MAX_W-1:0] MAP = pswd_pkg::default_map(N_EXT, N_INT, N_PART),
  localparam int PSEL_W = (N_PART > 1) ? $clog2(N_PART) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_en_i,
  input  logic [PSEL_W-1:0] part_sel_i,
  input  logic [N_EXT-1:0]  scan_ext_i,
  output logic [N_INT-1:0]  scan_int_o
);

  logic              rst_sync_n;
  logic [PSEL_W-1:0] part_act;

  pswd_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  pswd_part_reg #(
    .N_PART (N_PART),
    .PSEL_W (PSEL_W)
  ) u_part_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .scan_en_i (scan_en_i),
    .sel_i     (part_sel_i),
    .part_o    (part_act)
  );

  for (genvar c = 0; c < N_INT; c++) begin : g_chain
    pswd_chain_mux #(
      .N_EXT  (N_EXT),
      .N_INT  (N_INT),
      .N_PART (N_PART),
      .PSEL_W (PSEL_W),
      .CHAIN  (c),
      .MAP    (MAP)
    ) u_mux (
      .ext_i   (scan_ext_i),
      .part_i  (part_act),
      .chain_o (scan_int_o[c])
    );
  end

  // R8: the output path holds no state of its own
  a_r8_no_hidden_state: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (scan_en_i && $past(scan_en_i) && $stable(scan_ext_i)) |-> $stable(scan_int_o));

endmodule

// File: tb/scan_width_decomp_tb.sv
module scan_width_decomp_tb_top;

  localparam int N_EXT  = 16;
  localparam int N_INT  = 64;
  localparam int N_PART = 3;
  localparam int PSEL_W = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              scan_en_i;
  logic [PSEL_W-1:0] part_sel_i;
  logic [N_EXT-1:0]  scan_ext_i;
  logic [N_INT-1:0]  scan_int_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  scan_width_decomp dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scan_en_i  (scan_en_i),
    .part_sel_i (part_sel_i),
    .scan_ext_i (scan_ext_i),
    .scan_int_o (scan_int_o)
  );

  // Expected chain vector from the R2/R3 rules
  function automatic logic [N_INT-1:0] expect_vec(int p, logic [N_EXT-1:0] ext);
    logic [N_INT-1:0] v;
    int a, b, md;
    for (int c = 0; c < N_INT; c++) begin
      a  = (c * (2 * p + 1) + p) % N_EXT;
      b  = (a + p + 1) % N_EXT;
      md = ((c / N_EXT) + p) % 4;
      case (md)
        0:       v[c] = ext[a];
        1:       v[c] = ~ext[a];
        2:       v[c] = ext[a] ^ ext[b];
        default: v[c] = ~(ext[a] ^ ext[b]);
      endcase
    end
    return v;
  endfunction

  task automatic check_vec(string tag, int p);
    logic [N_INT-1:0] exp_v;
    exp_v = expect_vec(p, scan_ext_i);
    n_checks++;
    if (scan_int_o !== exp_v) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h (partition %0d)", tag, scan_int_o, exp_v, p);
    end
  endtask

  task automatic load_part(logic [PSEL_W-1:0] p);
    @(negedge clk_i);
    scan_en_i  = 1'b0;
    part_sel_i = p;
    @(negedge clk_i);
    scan_en_i  = 1'b1;
  endtask

  task automatic apply_ext(logic [N_EXT-1:0] v);
    @(negedge clk_i);
    scan_ext_i = v;
    #1;
  endtask

  // R7: partition 0 active after reset
  task automatic t_reset();
    rst_ni     = 1'b0;
    scan_en_i  = 1'b1;
    part_sel_i = 2'd2;
    scan_ext_i = 16'hA5C3;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    #1;
    check_vec("R7 reset partition", 0);
    apply_ext(16'h0F0F);
    check_vec("R7 reset partition pattern 2", 0);
  endtask

  // R1 R2 R3 R4: every partition, several patterns
  task automatic t_all_parts();
    logic [N_EXT-1:0] pats [5];
    pats[0] = 16'h0000;
    pats[1] = 16'hFFFF;
    pats[2] = 16'h0001;
    pats[3] = 16'h8000;
    pats[4] = 16'h3C5A;
    for (int p = 0; p < N_PART; p++) begin
      load_part(p[PSEL_W-1:0]);
      for (int k = 0; k < 5; k++) begin
        apply_ext(pats[k]);
        check_vec("R1 R2 R3 R4 fixed pattern", p);
      end
      for (int k = 0; k < 16; k++) begin
        apply_ext(16'(1 << k));
        check_vec("R1 R2 R3 walking one", p);
      end
      for (int k = 0; k < 20; k++) begin
        apply_ext(16'($urandom));
        check_vec("R1 R3 random pattern", p);
      end
    end
  endtask

  // R4: random order of loads
  task automatic t_random_loads();
    int p;
    for (int k = 0; k < 30; k++) begin
      p = int'($urandom % N_PART);
      load_part(p[PSEL_W-1:0]);
      apply_ext(16'($urandom));
      check_vec("R4 random load", p);
    end
  endtask

  // R5: select changes while shifting are not taken
  task automatic t_hold();
    load_part(2'd1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      part_sel_i = 2'(k % 3);
      scan_ext_i = 16'($urandom);
      #1;
      check_vec("R5 hold during shift", 1);
    end
  endtask

  // R6: out-of-range request ignored
  task automatic t_out_of_range();
    load_part(2'd2);
    load_part(2'd3);
    apply_ext(16'h9E37);
    check_vec("R6 out of range ignored", 2);
    load_part(2'd0);
    load_part(2'd3);
    apply_ext(16'h1234);
    check_vec("R6 out of range ignored from 0", 0);
  endtask

  // R8: output responds inside the cycle
  task automatic t_comb();
    load_part(2'd1);
    @(posedge clk_i);
    #1;
    scan_ext_i = 16'h00FF;
    #1;
    check_vec("R8 same cycle response a", 1);
    scan_ext_i = 16'hFF00;
    #1;
    check_vec("R8 same cycle response b", 1);
  endtask

  initial begin
    t_reset();
    t_all_parts();
    t_random_loads();
    t_hold();
    t_out_of_range();
    t_comb();
    repeat (2) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule